// File: doc/BRIEF.md
# Flash Status-Register Write Sequencer

This block drives a serial NOR flash through a byte-level SPI master handshake to update the flash's status register, then waits until the flash reports that the internal write has finished. A request carries a new status byte and a two-bit mode. The mode picks the one-byte enable command sent ahead of the write. It can also pick a brute-force unprotect operation, which reads the status, clears the block-protect field, writes the result back and reads the status once more to confirm the change.

After the write command the sequencer waits a fixed settle time before it reads the status for the first time, because some parts accept only one early status read. It then reads at a slower fixed interval for as long as the busy flag stays set, up to a bounded number of reads. In the fallback mode, a write that times out behind the general enable is repeated once behind the dedicated status-enable opcode. The block ends each operation with a one-cycle done pulse, and that pulse carries an error flag or a timeout flag when the operation did not succeed. All delays are counted in clock ticks and are set by parameters.

The SPI shift engine sits outside this block. For each byte the sequencer pulses `spi_go` with `spi_tx` while chip select is low. The engine answers with one `spi_ack` pulse and the byte it received on `spi_rx`.

Top module: `flash_sr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `done`, `err`, `timeout` and `spi_go` are 0 and `spi_cs_n` is 1.
- R2: A status write is two chip-select frames. The first frame is the single byte 0x06 when mode 0 (general enable) is used, or 0x50 when mode 1 (status enable) is used. The second frame is 0x01 followed by exactly one data byte. `spi_cs_n` is high for at least one cycle between frames, and `spi_go` pulses only while `spi_cs_n` is low.
- R3: A status read is the frame 0x05 followed by one dummy byte, and the status is the second byte received. The first read after a write frame begins at least FIRST_WAIT_TICKS cycles after that write frame ends.
- R4: While the status returns bit 0 (busy) set, a new read begins at least POLL_WAIT_TICKS cycles after the previous one ends. The first read with bit 0 clear ends the write with a single-cycle `done` and with `err` and `timeout` both 0.
- R5: If MAX_POLLS+1 consecutive reads after a write all show bit 0 set, and no fallback is left, the operation ends with `done` and `timeout` both 1, and no further read is issued.
- R6: Mode 2 (enable with fallback) first writes behind 0x06. If that write times out, the whole write is repeated once behind 0x50 with a fresh read budget, and only the outcome of the second write is reported.
- R7: Mode 3 (unprotect) first reads the status. If bits 2 to 5 (mask 0x3C) are all 0, it ends with `done` and no error, and sends no write.
- R8: Otherwise mode 3 writes the read value with bits 2 to 5 cleared, following the mode 2 enable rules, waits for bit 0 to clear and reads the status again. `err` is 1 with `done` exactly when any of bits 2 to 5 is still set in that last read.
- R9: `saved_status` holds the status byte read at the start of the most recent mode 3 operation, so that it can be written back later.
- R10: `req_valid` is taken only while `busy` is 0. `busy` is 1 from the cycle after acceptance up to and including the `done` cycle, and a request raised while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation (taken when idle) |
| req_mode | input | 2 | 0 general enable, 1 status enable, 2 enable with fallback, 3 unprotect |
| req_status | input | 8 | Status byte to write (modes 0 to 2) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | With done: protect bits still set after unprotect |
| timeout | output | 1 | With done: busy flag never cleared |
| saved_status | output | 8 | Status read at the start of the last unprotect |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_go | output | 1 | Request the engine to shift one byte |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Engine finished the byte |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |

## Verification
`busy` is due exactly one cycle after the accepting edge, and the bench samples it at the next falling edge. The length of an operation depends on the engine latency and on how many busy reads the flash model returns. For that reason the bench does not count a fixed number of cycles to `done`: it waits for the pulse within a bounded window and reads `err` and `timeout` in that same sample. The settle time and the poll spacing are checked as lower bounds between chip-select edges seen by the flash model. The design's own gap is the parameter plus two cycles of framing and hand-off. The final flash contents, the frame counts and the enable opcodes are compared after `done`, once the model has settled.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef enum logic [1:0] {
        MODE_WREN      = 2'd0,
        MODE_EWSR      = 2'd1,
        MODE_FALLBACK  = 2'd2,
        MODE_UNPROTECT = 2'd3
    } seq_mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UP_READ,
        S_PREAMBLE,
        S_WRITE,
        S_HOLD,
        S_POLL,
        S_GAP,
        S_VERIFY,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_XFER,
        F_GAP
    } frm_state_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_EWSR  = 8'h50;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] BP_MASK  = 8'h3C;
    localparam int         BUSY_BIT = 0;

endpackage

// File: rtl/flash_sr_timer.sv
module flash_sr_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == W'(1));
endmodule

// File: rtl/flash_sr_framer.sv
module flash_sr_framer
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       two_bytes,
    input  logic [7:0] byte0,
    input  logic [7:0] byte1,
    output logic       done,
    output logic [7:0] rx_last,
    output logic       spi_cs_n,
    output logic       spi_go,
    output logic [7:0] spi_tx,
    input  logic       spi_ack,
    input  logic [7:0] spi_rx
);
    frm_state_e state;
    logic       second;
    logic       on_second;
    logic [7:0] b1_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= F_IDLE;
            spi_cs_n  <= 1'b1;
            spi_go    <= 1'b0;
            spi_tx    <= 8'h00;
            second    <= 1'b0;
            on_second <= 1'b0;
            b1_r      <= 8'h00;
            rx_last   <= 8'h00;
            done      <= 1'b0;
        end else begin
            spi_go <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                F_IDLE: begin
                    if (start) begin
                        spi_cs_n  <= 1'b0;
                        spi_tx    <= byte0;
                        b1_r      <= byte1;
                        second    <= two_bytes;
                        on_second <= 1'b0;
                        spi_go    <= 1'b1;
                        state     <= F_XFER;
                    end
                end
                F_XFER: begin
                    if (spi_ack) begin
                        rx_last <= spi_rx;
                        if (second && !on_second) begin
                            on_second <= 1'b1;
                            spi_tx    <= b1_r;
                            spi_go    <= 1'b1;
                        end else begin
                            spi_cs_n <= 1'b1;
                            state    <= F_GAP;
                        end
                    end
                end
                F_GAP: begin
                    done  <= 1'b1;
                    state <= F_IDLE;
                end
                default: state <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_sr_seq.sv
module flash_sr_seq
    import flash_sr_pkg::*;
#(
    parameter int FIRST_WAIT_TICKS = 10_000_000,
    parameter int POLL_WAIT_TICKS  = 1_000_000,
    parameter int MAX_POLLS        = 490
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic [7:0] req_status,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic       timeout,
    output logic [7:0] saved_status,
    output logic       spi_cs_n,
    output logic       spi_go,
    output logic [7:0] spi_tx,
    input  logic       spi_ack,
    input  logic [7:0] spi_rx
);
    localparam int MAXT = (FIRST_WAIT_TICKS > POLL_WAIT_TICKS) ? FIRST_WAIT_TICKS : POLL_WAIT_TICKS;
    localparam int TW   = $clog2(MAXT + 1);
    localparam int PW   = $clog2(MAX_POLLS + 2);

    seq_state_e    state, state_n;
    logic [7:0]    wr_data, wr_data_n;
    logic          use_ewsr, use_ewsr_n;
    logic          may_fall, may_fall_n;
    logic          unprot, unprot_n;
    logic [PW-1:0] polls, polls_n;
    logic          err_r, err_n;
    logic          tmo_r, tmo_n;
    logic [7:0]    saved_r, saved_n;

    logic          fr_start, fr_two, fr_done;
    logic [7:0]    fr_b0, fr_b1, fr_rx;
    logic          tmr_load, tmr_expire;
    logic [TW-1:0] tmr_val;
    logic          rd_busy, bp_left;

    flash_sr_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fr_start),
        .two_bytes (fr_two),
        .byte0     (fr_b0),
        .byte1     (fr_b1),
        .done      (fr_done),
        .rx_last   (fr_rx),
        .spi_cs_n  (spi_cs_n),
        .spi_go    (spi_go),
        .spi_tx    (spi_tx),
        .spi_ack   (spi_ack),
        .spi_rx    (spi_rx)
    );

    flash_sr_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    assign rd_busy = fr_rx[BUSY_BIT];
    assign bp_left = |(fr_rx & BP_MASK);

    // next state, datapath updates and command strobes
    always_comb begin
        state_n    = state;
        wr_data_n  = wr_data;
        use_ewsr_n = use_ewsr;
        may_fall_n = may_fall;
        unprot_n   = unprot;
        polls_n    = polls;
        err_n      = err_r;
        tmo_n      = tmo_r;
        saved_n    = saved_r;
        fr_start   = 1'b0;
        fr_two     = 1'b1;
        fr_b0      = OP_RDSR;
        fr_b1      = 8'h00;
        tmr_load   = 1'b0;
        tmr_val    = TW'(FIRST_WAIT_TICKS);
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    err_n   = 1'b0;
                    tmo_n   = 1'b0;
                    polls_n = '0;
                    if (req_mode == MODE_UNPROTECT) begin
                        unprot_n   = 1'b1;
                        use_ewsr_n = 1'b0;
                        may_fall_n = 1'b1;
                        fr_start   = 1'b1;
                        state_n    = S_UP_READ;
                    end else begin
                        unprot_n   = 1'b0;
                        wr_data_n  = req_status;
                        use_ewsr_n = (req_mode == MODE_EWSR);
                        may_fall_n = (req_mode == MODE_FALLBACK);
                        fr_start   = 1'b1;
                        fr_two     = 1'b0;
                        fr_b0      = (req_mode == MODE_EWSR) ? OP_EWSR : OP_WREN;
                        state_n    = S_PREAMBLE;
                    end
                end
            end
            S_UP_READ: begin
                if (fr_done) begin
                    saved_n = fr_rx;
                    if (!bp_left) begin
                        state_n = S_DONE;
                    end else begin
                        wr_data_n = fr_rx & ~BP_MASK;
                        fr_start  = 1'b1;
                        fr_two    = 1'b0;
                        fr_b0     = OP_WREN;
                        state_n   = S_PREAMBLE;
                    end
                end
            end
            S_PREAMBLE: begin
                if (fr_done) begin
                    fr_start = 1'b1;
                    fr_b0    = OP_WRSR;
                    fr_b1    = wr_data;
                    state_n  = S_WRITE;
                end
            end
            S_WRITE: begin
                if (fr_done) begin
                    tmr_load = 1'b1;
                    state_n  = S_HOLD;
                end
            end
            S_HOLD: begin
                if (tmr_expire) begin
                    fr_start = 1'b1;
                    state_n  = S_POLL;
                end
            end
            S_POLL: begin
                if (fr_done) begin
                    if (!rd_busy) begin
                        if (unprot) begin
                            fr_start = 1'b1;
                            state_n  = S_VERIFY;
                        end else begin
                            state_n = S_DONE;
                        end
                    end else if (polls == PW'(MAX_POLLS)) begin
                        if (may_fall && !use_ewsr) begin
                            use_ewsr_n = 1'b1;
                            may_fall_n = 1'b0;
                            polls_n    = '0;
                            fr_start   = 1'b1;
                            fr_two     = 1'b0;
                            fr_b0      = OP_EWSR;
                            state_n    = S_PREAMBLE;
                        end else begin
                            tmo_n   = 1'b1;
                            state_n = S_DONE;
                        end
                    end else begin
                        polls_n  = polls + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(POLL_WAIT_TICKS);
                        state_n  = S_GAP;
                    end
                end
            end
            S_GAP: begin
                if (tmr_expire) begin
                    fr_start = 1'b1;
                    state_n  = S_POLL;
                end
            end
            S_VERIFY: begin
                if (fr_done) begin
                    err_n   = bp_left;
                    state_n = S_DONE;
                end
            end
            S_DONE: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            wr_data  <= 8'h00;
            use_ewsr <= 1'b0;
            may_fall <= 1'b0;
            unprot   <= 1'b0;
            polls    <= '0;
            err_r    <= 1'b0;
            tmo_r    <= 1'b0;
            saved_r  <= 8'h00;
        end else begin
            state    <= state_n;
            wr_data  <= wr_data_n;
            use_ewsr <= use_ewsr_n;
            may_fall <= may_fall_n;
            unprot   <= unprot_n;
            polls    <= polls_n;
            err_r    <= err_n;
            tmo_r    <= tmo_n;
            saved_r  <= saved_n;
        end
    end

    // outputs
    always_comb begin
        busy         = (state != S_IDLE);
        done         = (state == S_DONE);
        err          = (state == S_DONE) && err_r;
        timeout      = (state == S_DONE) && tmo_r;
        saved_status = saved_r;
    end
endmodule

// File: rtl/flash_sr_seq_chk.sv
module flash_sr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       timeout,
    input logic       spi_cs_n,
    input logic       spi_go
);
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n); // R2

    AST_GO_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |-> !spi_cs_n); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (done && !err)); // R5

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_go)); // R10

    AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R10
endmodule

bind flash_sr_seq flash_sr_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .timeout   (timeout),
    .spi_cs_n  (spi_cs_n),
    .spi_go    (spi_go)
);

// File: tb/tb_flash_sr_seq.sv
module tb_flash_sr_seq;
    localparam int FIRST = 20;
    localparam int POLL  = 6;
    localparam int MAXP  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [7:0] req_status = 8'h00;
    logic       busy, done, err, timeout;
    logic [7:0] saved_status;
    logic       spi_cs_n, spi_go;
    logic [7:0] spi_tx;
    logic       spi_ack = 1'b0;
    logic [7:0] spi_rx = 8'hFF;

    always #5 clk = ~clk;

    flash_sr_seq #(
        .FIRST_WAIT_TICKS (FIRST),
        .POLL_WAIT_TICKS  (POLL),
        .MAX_POLLS        (MAXP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_status(req_status), .busy(busy), .done(done), .err(err),
        .timeout(timeout), .saved_status(saved_status), .spi_cs_n(spi_cs_n),
        .spi_go(spi_go), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    // flash model configuration, written by the bench only
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_init = 8'h00;
    int         cfg_busy = 0;
    logic       cfg_stuck = 1'b0;
    logic       cfg_lock = 1'b0;

    // flash model state
    logic [7:0] m_sr = 8'h00;
    logic       m_wel = 1'b0, m_ewsr = 1'b0;
    int         m_busy_left = 0;
    int         m_idx = 0;
    logic [7:0] m_op = 8'h00, m_tx = 8'h00, last_pre = 8'h00, prev_op = 8'h00;
    logic       prev_busy = 1'b0, cs_q = 1'b1, pending = 1'b0;
    int         lat = 0, cyc = 0, frame_start = 0, last_end = 0;
    int         n_reads = 0, n_pre = 0, n_writes = 0, n_badframe = 0, n_badgap = 0;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        spi_ack <= 1'b0;
        cs_q    <= spi_cs_n;
        if (cfg_load) begin
            m_sr <= cfg_init & 8'hFC; m_wel <= 1'b0; m_ewsr <= 1'b0; m_busy_left <= 0;
            n_reads <= 0; n_pre <= 0; n_writes <= 0; n_badframe <= 0; n_badgap <= 0;
            last_pre <= 8'h00;
        end
        if (!busy) prev_op <= 8'h00;
        if (cs_q && !spi_cs_n) frame_start <= cyc;
        if (!cs_q && spi_cs_n) begin
            last_end <= cyc;
            prev_op  <= m_op;
            m_idx    <= 0;
            if (((m_op == 8'h06 || m_op == 8'h50) && m_idx != 1) ||
                ((m_op == 8'h01 || m_op == 8'h05) && m_idx != 2))
                n_badframe <= n_badframe + 1;
        end
        if (spi_go) begin
            m_tx <= spi_tx; pending <= 1'b1; lat <= 2;
        end else if (pending) begin
            if (lat > 0) begin
                lat <= lat - 1;
            end else begin
                pending <= 1'b0;
                spi_ack <= 1'b1;
                spi_rx  <= 8'hFF;
                m_idx   <= m_idx + 1;
                if (m_idx == 0) begin
                    m_op <= m_tx;
                    if (m_tx == 8'h06) begin
                        m_wel <= 1'b1; n_pre <= n_pre + 1; last_pre <= 8'h06;
                    end else if (m_tx == 8'h50) begin
                        m_ewsr <= 1'b1; n_pre <= n_pre + 1; last_pre <= 8'h50;
                    end else if (m_tx == 8'h05) begin
                        n_reads <= n_reads + 1;
                        if (prev_op == 8'h01 && (frame_start - last_end) < FIRST)
                            n_badgap <= n_badgap + 1;
                        if (prev_op == 8'h05 && prev_busy && (frame_start - last_end) < POLL)
                            n_badgap <= n_badgap + 1;
                    end
                end else if (m_idx == 1) begin
                    if (m_op == 8'h05) begin
                        spi_rx    <= {m_sr[7:2], m_wel, (m_busy_left != 0)};
                        prev_busy <= (m_busy_left != 0);
                        if (m_busy_left > 0) m_busy_left <= m_busy_left - 1;
                    end else if (m_op == 8'h01 && (m_wel || m_ewsr)) begin
                        n_writes    <= n_writes + 1;
                        m_sr        <= cfg_lock ? {m_tx[7:6], m_sr[5:2], 2'b00} : {m_tx[7:2], 2'b00};
                        m_busy_left <= (cfg_stuck && m_wel) ? 200 : cfg_busy;
                        m_wel       <= 1'b0;
                        m_ewsr      <= 1'b0;
                    end
                end
            end
        end
    end

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [7:0] init, input int nb, input logic stuck, input logic lock);
        @(negedge clk);
        cfg_init = init; cfg_busy = nb; cfg_stuck = stuck; cfg_lock = lock; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output logic g_err, output logic g_tmo);
        seen = 1'b0; g_err = 1'b0; g_tmo = 1'b0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; g_err = err; g_tmo = timeout; end
        end
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] data;
        logic [7:0] init;
        logic [7:0] nbusy;
        logic       stuck;
        logic       lock;
        logic       e_err;
        logic       e_tmo;
        logic [7:0] e_reads;
        logic [7:0] e_pre;
        logic [7:0] e_last;
        logic [7:0] e_sr;
        logic [7:0] e_wr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h80, 8'h00, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 8'd1, 8'h06, 8'h80, 8'd1},
        '{2'd1, 8'h1C, 8'h00, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 8'h50, 8'h1C, 8'd1},
        '{2'd0, 8'h40, 8'h00, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 8'd1, 8'h06, 8'h40, 8'd1},
        '{2'd0, 8'h20, 8'h00, 8'd4, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4, 8'd1, 8'h06, 8'h20, 8'd1},
        '{2'd2, 8'h3C, 8'h00, 8'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6, 8'd2, 8'h50, 8'h3C, 8'd2},
        '{2'd2, 8'hC4, 8'h00, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 8'h06, 8'hC4, 8'd1},
        '{2'd0, 8'h08, 8'h00, 8'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd4, 8'd1, 8'h06, 8'h08, 8'd1},
        '{2'd3, 8'h00, 8'h00, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd0, 8'h00, 8'h00, 8'd0},
        '{2'd3, 8'h00, 8'hBC, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 8'd1, 8'h06, 8'h80, 8'd1},
        '{2'd3, 8'h00, 8'h24, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3, 8'd1, 8'h06, 8'h24, 8'd1},
        '{2'd3, 8'h00, 8'h0C, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7, 8'd2, 8'h50, 8'h00, 8'd2},
        '{2'd1, 8'hFF, 8'h00, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 8'h50, 8'hFC, 8'd1}
    };

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        bit   seen;
        logic g_err, g_tmo;
        string tag;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(!busy && !done && !err && !timeout, "R1", "flags in reset", {busy, done, err, timeout}, 0);
        check(spi_cs_n && !spi_go, "R1", "spi idle in reset", {spi_cs_n, spi_go}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && spi_cs_n && !spi_go, "R1", "first cycle after reset",
              {busy, done, spi_cs_n, spi_go}, 2);

        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC[v].init, int'(VEC[v].nbusy), VEC[v].stuck, VEC[v].lock);
            @(negedge clk);
            req_valid = 1'b1; req_mode = VEC[v].mode; req_status = VEC[v].data;
            @(negedge clk);
            req_valid = 1'b0;
            wait_done(seen, g_err, g_tmo);
            if (VEC[v].e_tmo)                               tag = "R5";
            else if (VEC[v].mode == 2'd3 && VEC[v].e_wr == 0) tag = "R7";
            else if (VEC[v].mode == 2'd3)                   tag = "R8";
            else if (VEC[v].mode == 2'd2)                   tag = "R6";
            else                                            tag = "R4";
            check(seen, tag, $sformatf("v%0d done seen", v), seen, 1);
            check(g_err == VEC[v].e_err, tag, $sformatf("v%0d err", v), g_err, VEC[v].e_err);
            check(g_tmo == VEC[v].e_tmo, tag, $sformatf("v%0d timeout", v), g_tmo, VEC[v].e_tmo);
            check(n_reads == int'(VEC[v].e_reads), tag, $sformatf("v%0d status reads", v), n_reads, VEC[v].e_reads);
            check(n_pre == int'(VEC[v].e_pre), "R2", $sformatf("v%0d enable frames", v), n_pre, VEC[v].e_pre);
            check(last_pre == VEC[v].e_last, "R2", $sformatf("v%0d last enable opcode", v), last_pre, VEC[v].e_last);
            check(n_writes == int'(VEC[v].e_wr), tag, $sformatf("v%0d write frames", v), n_writes, VEC[v].e_wr);
            check(m_sr == VEC[v].e_sr, tag, $sformatf("v%0d flash status", v), m_sr, VEC[v].e_sr);
            check(n_badframe == 0, "R2", $sformatf("v%0d frame length errors", v), n_badframe, 0);
            check(n_badgap == 0, "R3", $sformatf("v%0d read spacing errors", v), n_badgap, 0);
            if (VEC[v].mode == 2'd3)
                check(saved_status == VEC[v].init, "R9", $sformatf("v%0d saved status", v), saved_status, VEC[v].init);
        end

        // R9: a write request leaves saved_status from the last unprotect (0x0C)
        check(saved_status == 8'h0C, "R9", "saved after write mode", saved_status, 8'h0C);

        // R10: busy one cycle after acceptance, request while busy ignored
        set_cfg(8'h00, 2, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd0; req_status = 8'h44;
        @(negedge clk);
        check(busy, "R10", "busy after accept", busy, 1);
        req_mode = 2'd1; req_status = 8'h10;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen, g_err, g_tmo);
        check(seen && !g_err && !g_tmo, "R10", "first request completes", {seen, g_err, g_tmo}, 4);
        check(m_sr == 8'h44, "R10", "status from accepted request", m_sr, 8'h44);
        check(last_pre == 8'h06 && n_pre == 1, "R10", "ignored request sent no enable", last_pre, 8'h06);
        repeat (30) @(negedge clk);
        check(!busy && n_writes == 1, "R10", "no second operation", n_writes, 1);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule